// File: doc/BRIEF.md
# Hint-Guided Cache Replacement Policy

This block makes the replacement decision for one set-associative cache. Each access presents a set index, a hit flag, the hit way and a two-bit locality hint from the memory operation. The block keeps, per line, a valid bit and a keep or evict mark, and per set a true-LRU order and a decay counter. It never looks at tags or data; the surrounding cache owns those and reports only the hit result.

On a miss the block picks the way to refill and presents it one cycle later with a strobe. In the same update it records the refilled line as most recently used and stores the request's hint on it. The choice goes in this order: an empty way first, then a line the software called dead, then an unprotected line, and only then a protected one. Marks only matter when a victim is chosen. A per-set decay counter removes keep protection after a set number of misses, so lines marked keep cannot pin a set forever.

Top module: `hint_repl`

## Requirements
- R1: After reset `vic_valid` is low, every line is invalid and unmarked, and the age order of each set is way index (way 0 youngest, way WAYS-1 oldest). The first four misses to an untouched set therefore return ways 0, 1, 2, 3.
- R2: A miss request (`req_valid`=1, `req_hit`=0) sampled at clock edge t gives `vic_valid`=1 with the victim on `vic_way` after edge t, for exactly one cycle. A hit or an idle cycle gives `vic_valid`=0 in the following cycle. A hit never evicts anything.
- R3: If the set holds an invalid way, the lowest-numbered invalid way is the victim, whatever the marks and ages are.
- R4: With all ways valid, a way marked evict is chosen ahead of every other way. Among several evict-marked ways, the least recently used one is chosen.
- R5: With all ways valid and no evict mark present, the least recently used unmarked way is chosen. A keep-marked way is not chosen while any unmarked way exists.
- R6: With every way valid and keep-marked, the least recently used way of the set is chosen.
- R7: A hit makes the hit way the most recently used. A miss makes the victim way the most recently used. Ways that were younger than the touched way each age by one.
- R8: Hint encoding: 2'b00 none, 2'b01 keep, 2'b10 evict, 2'b11 none. A hit with keep or evict replaces that line's mark. A hit with none or 2'b11 leaves the mark unchanged.
- R9: A refilled line takes the mark of its miss request. A miss with hint none or 2'b11 leaves the refilled line unmarked.
- R10: Each set counts its misses in a saturating DECAY_W-bit counter. When a miss brings the count to `decay_limit` or above (with `decay_limit` nonzero), all keep marks in that set are cleared and the counter returns to 0. The victim of that miss is still chosen with the old marks, and the refilled line then takes its own hint. A `decay_limit` of 0 disables decay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access present this cycle |
| req_set | input | SET_W (6) | Set index of the access |
| req_hit | input | 1 | Access hit in the cache |
| req_way | input | WAY_W (2) | Hit way; ignored on a miss |
| req_hint | input | 2 | Locality hint of the access |
| decay_limit | input | DECAY_W (4) | Miss count that clears keep marks; 0 disables decay |
| vic_valid | output | 1 | Victim strobe, one cycle after a miss |
| vic_way | output | WAY_W (2) | Way chosen for the refill |

## Verification
Directed sequences on untouched sets separate the four priority levels from each other. Empty ways must fill in index order. An evict-marked line must beat an older line. A keep-marked oldest line must be passed over for the next oldest. A set that is all keep must fall back to plain LRU. Further sequences tell a hit with hint 2'b11 (mark kept) from a hit with keep (mark replaced), and follow a set across the decay threshold to show that protection disappears on the miss that crosses it and not before. A long stretch of random hits, misses and hints, including 2'b11, goes to a few sets at both ends of the index range with changing decay limits. Each victim is compared against a bench reference of the ordering, which exposes any mistake in the age update that only shows up after several accesses.

// File: rtl/hint_repl_pkg.sv
package hint_repl_pkg;

    typedef enum logic [1:0] {
        HINT_NONE  = 2'b00,
        HINT_KEEP  = 2'b01,
        HINT_EVICT = 2'b10,
        HINT_RSVD  = 2'b11
    } hint_e;

    typedef struct packed {
        logic keep;
        logic evict;
    } mark_t;

    // Translate a raw hint into the stored per-line mark
    function automatic mark_t hint_to_mark(logic [1:0] raw);
        mark_t m;
        m = '0;
        case (hint_e'(raw))
            HINT_KEEP:  m.keep  = 1'b1;
            HINT_EVICT: m.evict = 1'b1;
            default:    m = '0;
        endcase
        return m;
    endfunction

    // True when the hint carries information that overwrites a mark on a hit
    function automatic logic hint_is_active(logic [1:0] raw);
        return (hint_e'(raw) == HINT_KEEP) || (hint_e'(raw) == HINT_EVICT);
    endfunction

endpackage

// File: rtl/hr_victim_sel.sv
module hr_victim_sel #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             line_valid,
    input  logic [WAYS-1:0]             line_keep,
    input  logic [WAYS-1:0]             line_evict,
    input  logic [WAYS-1:0][WAY_W-1:0]  line_age,
    output logic [WAY_W-1:0]            victim
);

    logic [WAYS-1:0]  empty;
    logic [WAYS-1:0]  plain;
    logic [WAYS-1:0]  cand;
    logic [WAY_W-1:0] first_empty;
    logic [WAY_W-1:0] oldest;
    logic [WAY_W-1:0] best_age;
    logic             found;

    assign empty = ~line_valid;
    assign plain = ~line_keep & ~line_evict;

    // Candidate mask by priority: evict-marked, then unmarked, then all
    always_comb begin
        if (|line_evict)      cand = line_evict;
        else if (|plain)      cand = plain;
        else                  cand = '1;
    end

    // Lowest-numbered empty way
    always_comb begin
        first_empty = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (empty[w]) first_empty = WAY_W'(w);
        end
    end

    // Oldest way among the candidates (ages are a permutation)
    always_comb begin
        oldest   = '0;
        best_age = '0;
        found    = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (cand[w] && (!found || line_age[w] > best_age)) begin
                oldest   = WAY_W'(w);
                best_age = line_age[w];
                found    = 1'b1;
            end
        end
    end

    assign victim = (|empty) ? first_empty : oldest;

endmodule

// File: rtl/hr_age_update.sv
module hr_age_update #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_in,
    input  logic [WAY_W-1:0]           touch,
    output logic [WAYS-1:0][WAY_W-1:0] age_out
);

    logic [WAY_W-1:0] touch_age;

    assign touch_age = age_in[touch];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_comb begin
            if (WAY_W'(w) == touch)          age_out[w] = '0;
            else if (age_in[w] < touch_age)  age_out[w] = age_in[w] + 1'b1;
            else                             age_out[w] = age_in[w];
        end
    end

endmodule

// File: rtl/hr_decay.sv
module hr_decay #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [CNT_W-1:0] limit,
    input  logic             miss,
    output logic [CNT_W-1:0] cnt_out,
    output logic             fire
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0] bumped;

    assign bumped = {1'b0, cnt_in} + 1'b1;
    assign fire   = miss && (limit != '0) && (bumped >= {1'b0, limit});

    always_comb begin
        if (fire)                         cnt_out = '0;
        else if (miss && cnt_in != CNT_MAX) cnt_out = bumped[CNT_W-1:0];
        else                              cnt_out = cnt_in;
    end

endmodule

// File: rtl/hint_repl.sv
module hint_repl
    import hint_repl_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int SETS    = 64,
    parameter int DECAY_W = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [SET_W-1:0]   req_set,
    input  logic               req_hit,
    input  logic [WAY_W-1:0]   req_way,
    input  logic [1:0]         req_hint,
    input  logic [DECAY_W-1:0] decay_limit,
    output logic               vic_valid,
    output logic [WAY_W-1:0]   vic_way
);

    // Replacement state, one entry per set
    logic [WAYS-1:0]             valid_q [SETS];
    logic [WAYS-1:0]             keep_q  [SETS];
    logic [WAYS-1:0]             evict_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0]  age_q   [SETS];
    logic [DECAY_W-1:0]          dcnt_q  [SETS];

    logic                        vic_valid_q;
    logic [WAY_W-1:0]            vic_way_q;

    logic [WAYS-1:0]             cur_valid, cur_keep, cur_evict;
    logic [WAYS-1:0][WAY_W-1:0]  cur_age, nxt_age;
    logic [DECAY_W-1:0]          cur_cnt, nxt_cnt;
    logic [WAYS-1:0]             nxt_keep, nxt_evict;
    logic                        is_miss;
    logic                        decay_fire;
    logic [WAY_W-1:0]            sel_way;
    logic [WAY_W-1:0]            touch;
    mark_t                       req_mark;

    assign cur_valid = valid_q[req_set];
    assign cur_keep  = keep_q[req_set];
    assign cur_evict = evict_q[req_set];
    assign cur_age   = age_q[req_set];
    assign cur_cnt   = dcnt_q[req_set];

    assign is_miss  = req_valid && !req_hit;
    assign touch    = is_miss ? sel_way : req_way;
    assign req_mark = hint_to_mark(req_hint);

    hr_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_sel (
        .line_valid (cur_valid),
        .line_keep  (cur_keep),
        .line_evict (cur_evict),
        .line_age   (cur_age),
        .victim     (sel_way)
    );

    hr_age_update #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
        .age_in  (cur_age),
        .touch   (touch),
        .age_out (nxt_age)
    );

    hr_decay #(.CNT_W(DECAY_W)) u_decay (
        .cnt_in  (cur_cnt),
        .limit   (decay_limit),
        .miss    (is_miss),
        .cnt_out (nxt_cnt),
        .fire    (decay_fire)
    );

    // Marks: decay clears keep first, then the touched line takes its hint
    always_comb begin
        nxt_keep  = decay_fire ? '0 : cur_keep;
        nxt_evict = cur_evict;
        if (is_miss || hint_is_active(req_hint)) begin
            nxt_keep[touch]  = req_mark.keep;
            nxt_evict[touch] = req_mark.evict;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                keep_q[s]  <= '0;
                evict_q[s] <= '0;
                dcnt_q[s]  <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
            vic_valid_q <= 1'b0;
            vic_way_q   <= '0;
        end else begin
            vic_valid_q <= is_miss;
            if (is_miss) vic_way_q <= sel_way;
            if (req_valid) begin
                age_q[req_set]   <= nxt_age;
                keep_q[req_set]  <= nxt_keep;
                evict_q[req_set] <= nxt_evict;
                dcnt_q[req_set]  <= nxt_cnt;
                if (is_miss) valid_q[req_set][touch] <= 1'b1;
            end
        end
    end

    assign vic_valid = vic_valid_q;
    assign vic_way   = vic_way_q;

    AST_MISS_YIELDS_VICTIM: assert property (@(posedge clk) disable iff (rst)
        is_miss |=> vic_valid);  // R2
    AST_VICTIM_NEEDS_MISS: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> $past(req_valid && !req_hit));  // R2
    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (is_miss && !(&cur_valid)) |-> !cur_valid[sel_way]);  // R3
    AST_EVICT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (is_miss && (&cur_valid) && (|cur_evict)) |-> cur_evict[sel_way]);  // R4
    AST_KEEP_SPARED: assert property (@(posedge clk) disable iff (rst)
        (is_miss && (&cur_valid) && !(|cur_evict) && !(&cur_keep)) |-> !cur_keep[sel_way]);  // R5

endmodule

// File: tb/hint_repl_tb.sv
module hint_repl_tb;

    localparam int WAYS = 4;
    localparam int SETS = 64;
    localparam int DW   = 4;
    localparam int WW   = $clog2(WAYS);
    localparam int SW   = $clog2(SETS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [SW-1:0] req_set = '0;
    logic          req_hit = 1'b0;
    logic [WW-1:0] req_way = '0;
    logic [1:0]    req_hint = 2'b00;
    logic [DW-1:0] decay_limit = '0;
    logic          vic_valid;
    logic [WW-1:0] vic_way;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state derived from the requirements
    bit m_valid [SETS][WAYS];
    bit m_keep  [SETS][WAYS];
    bit m_evict [SETS][WAYS];
    int m_age   [SETS][WAYS];
    int m_cnt   [SETS];

    always #2 clk = ~clk;  // 250 MHz

    hint_repl #(.WAYS(WAYS), .SETS(SETS), .DECAY_W(DW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
        .req_hit(req_hit), .req_way(req_way), .req_hint(req_hint),
        .decay_limit(decay_limit), .vic_valid(vic_valid), .vic_way(vic_way)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic void model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_cnt[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_keep[s][w] = 0; m_evict[s][w] = 0;
                m_age[s][w] = w;
            end
        end
    endfunction

    function automatic int model_victim(int s);
        bit any_ev = 0, any_plain = 0;
        int best = -1;
        for (int w = 0; w < WAYS; w++) if (!m_valid[s][w]) return w;
        for (int w = 0; w < WAYS; w++) begin
            if (m_evict[s][w]) any_ev = 1;
            if (!m_keep[s][w] && !m_evict[s][w]) any_plain = 1;
        end
        for (int w = 0; w < WAYS; w++) begin
            bit c;
            c = any_ev ? m_evict[s][w] : (any_plain ? (!m_keep[s][w] && !m_evict[s][w]) : 1'b1);
            if (c && (best < 0 || m_age[s][w] > m_age[s][best])) best = w;
        end
        return best;
    endfunction

    function automatic void model_apply(int s, bit hit, int t, int hint, int lim);
        int old = m_age[s][t];
        for (int w = 0; w < WAYS; w++) begin
            if (w == t) m_age[s][w] = 0;
            else if (m_age[s][w] < old) m_age[s][w]++;
        end
        if (!hit) begin
            if (lim != 0 && m_cnt[s] + 1 >= lim) begin
                for (int w = 0; w < WAYS; w++) m_keep[s][w] = 0;
                m_cnt[s] = 0;
            end else if (m_cnt[s] < (1 << DW) - 1) begin
                m_cnt[s]++;
            end
            m_valid[s][t] = 1;
        end
        if (!hit || hint == 1 || hint == 2) begin
            m_keep[s][t]  = (hint == 1);
            m_evict[s][t] = (hint == 2);
        end
    endfunction

    // One access; victim compared one edge later
    task automatic access(string req, int s, bit hit, int way, int hint);
        int exp_v = 0;
        @(negedge clk);
        if (!hit) exp_v = model_victim(s);
        model_apply(s, hit, hit ? way : exp_v, hint, int'(decay_limit));
        req_valid = 1'b1; req_set = SW'(s); req_hit = hit;
        req_way = WW'(way); req_hint = 2'(hint);
        @(posedge clk); #1;
        check({req, " strobe"}, int'(vic_valid), hit ? 0 : 1);
        if (!hit) check({req, " victim"}, int'(vic_way), exp_v);
        req_valid = 1'b0;
    endtask

    task automatic fill4(string req, int s, int h0, int h1, int h2, int h3);
        access(req, s, 0, 0, h0);
        access(req, s, 0, 0, h1);
        access(req, s, 0, 0, h2);
        access(req, s, 0, 0, h3);
    endtask

    initial begin
        void'($urandom(32'd7321));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 reset strobe", int'(vic_valid), 0);

        // R1/R3: empty ways fill in index order
        fill4("R1 R3 fill order", 5, 0, 0, 0, 0);
        access("R7 miss hits LRU", 5, 0, 0, 1);
        access("R8 hit sets evict", 5, 1, 1, 2);
        access("R4 evict beats LRU", 5, 0, 0, 0);
        access("R2 idle after hit", 5, 1, 2, 0);

        // R5: keep on the oldest line is skipped
        fill4("R5 fill", 9, 1, 0, 0, 0);
        access("R5 keep spared", 9, 0, 0, 0);

        // R4: two evict lines, oldest of them wins
        fill4("R4 fill", 14, 2, 0, 2, 0);
        access("R4 oldest evict", 14, 0, 0, 0);
        access("R4 next evict", 14, 0, 0, 0);

        // R6: all keep falls back to LRU
        fill4("R6 fill", 12, 1, 1, 1, 1);
        access("R7 hit refresh", 12, 1, 0, 0);
        access("R6 all keep LRU", 12, 0, 0, 1);

        // R8/R9: reserved hint behaves as none
        fill4("R9 fill", 20, 2, 0, 0, 3);
        access("R8 hit rsvd keeps mark", 20, 1, 0, 3);
        access("R8 evict survives", 20, 0, 0, 3);
        access("R8 hit keep overwrites", 20, 1, 0, 1);
        access("R9 rsvd fill unmarked", 20, 0, 0, 0);

        // R10: decay clears keeps on the threshold miss
        decay_limit = 4'd6;
        fill4("R10 fill", 30, 1, 1, 1, 1);
        access("R10 hit", 30, 1, 0, 0);
        access("R10 miss5", 30, 0, 0, 1);
        access("R10 miss6 fires", 30, 0, 0, 0);
        access("R10 after decay", 30, 0, 0, 0);
        access("R10 after decay2", 30, 0, 0, 0);
        decay_limit = 4'd0;

        // Random mix on sets at both ends of the range
        for (int i = 0; i < 4000; i++) begin
            int s, hint, way;
            bit hit;
            bit anyv;
            if (i % 500 == 0) decay_limit = DW'($urandom_range(0, 7));
            s = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 2) : SETS - 1 - $urandom_range(0, 1);
            hint = $urandom_range(0, 3);
            anyv = 0;
            for (int w = 0; w < WAYS; w++) if (m_valid[s][w]) anyv = 1;
            hit = anyv && ($urandom_range(0, 2) != 0);
            way = 0;
            if (hit) begin
                do way = $urandom_range(0, WAYS - 1); while (!m_valid[s][way]);
            end
            access("R2 R3 R4 R5 R6 R7 R10 random", s, hit, way, hint);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule